// File: doc/BRIEF.md
# Configurable Branch Direction Predictor

This block supplies a taken / not-taken guess for a conditional branch to the fetch stage and learns from resolved branches. A three-bit policy select chooses how the guess is formed: a fixed taken answer, a fixed not-taken answer, a guess from the sign of the branch displacement, a table of last outcomes with one bit per entry, or a table of two-bit saturating counters.

The lookup side takes the branch address and its target and answers in the same cycle, with no register on the path. The update side takes a resolved branch (address, target, actual direction) and writes both history tables on the next clock edge, whatever policy is selected. On each update the block also works out what it would have predicted for that branch under the current policy. If that guess was wrong, it advances a misprediction counter.

Both tables have 2^IDX_W entries. Each is indexed by the address bits just above the instruction alignment bits.

Top module: `bp_dir_predict`

## Requirements
- R1: With policy code 0 the lookup output is 1 for every address, target and history.
- R2: With policy code 1 the lookup output is 0 for every address, target and history.
- R3: With policy code 2 the output is 1 when the target is numerically below the branch address, and 0 when the target is equal to or above it.
- R4: With policy code 3 the output is the one-bit entry for the branch. Every update writes the actual direction (1 taken, 0 not taken) into that entry.
- R5: With policy code 4 the output is bit 1 of the two-bit entry (00 strongly not taken, 01 weakly not taken, 10 weakly taken, 11 strongly taken). A taken update adds one and stops at 11. A not-taken update subtracts one and stops at 00.
- R6: After reset every one-bit entry holds 0, every two-bit entry holds 01, and the misprediction count is 0.
- R7: The entry index is branch address bits [ALIGN+IDX_W-1:ALIGN]. Two addresses that differ only outside those bits share an entry.
- R8: When a lookup and an update select the same entry in the same cycle, the lookup returns the entry value from before that update.
- R9: On each valid update the misprediction count goes up by exactly one if the policy-selected prediction for the update address and target (from the pre-update tables) differs from the actual direction. Otherwise the count does not change. The count wraps at 2^CNT_W.
- R10: A loop branch taken nine times and then not taken, repeated, costs two mispredictions per repetition under code 3 and one under code 4, once warmed up.
- R11: Both tables are trained on every valid update regardless of the policy code, so switching policy immediately uses the trained history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Policy select, codes 0 to 4 |
| lkp_pc_i | input | PC_W | Address of the branch being looked up |
| lkp_target_i | input | PC_W | Target of the branch being looked up |
| lkp_taken_o | output | 1 | Same-cycle prediction, 1 means taken |
| upd_valid_i | input | 1 | A resolved branch is presented |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_target_i | input | PC_W | Target of the resolved branch |
| upd_taken_i | input | 1 | Actual direction of the resolved branch |
| miss_cnt_o | output | CNT_W | Misprediction count |

## Verification
The assertions assume that reset holds the update valid low and that the policy code stays in the range 0 to 4. They also assume that the history-based properties only apply while the lookup address maps to the entry just written. The bench keeps to these assumptions: it drives every input away from the clock edge, issues only the five defined codes, and keeps the update valid low throughout reset. Aliasing and same-entry collisions are created on purpose with addresses chosen for that.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [2:0] {
    POL_TAKEN   = 3'd0,
    POL_NOTTKN  = 3'd1,
    POL_DISP    = 3'd2,
    POL_LAST    = 3'd3,
    POL_BIMODAL = 3'd4
  } bp_policy_e;

  localparam logic [1:0] CTR_RESET = 2'b01;

  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    nxt = cur;
    if (taken && cur != 2'b11) nxt = cur + 2'd1;
    else if (!taken && cur != 2'b00) nxt = cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int unsigned        IDX_W = 6,
  parameter int unsigned        W     = 2,
  parameter logic [W-1:0]       INIT  = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] ra_idx_i,
  output logic [W-1:0]     ra_data_o,
  input  logic [IDX_W-1:0] rb_idx_i,
  output logic [W-1:0]     rb_data_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wa_idx_i,
  input  logic [W-1:0]     wdata_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT;
    end else if (we_i) begin
      mem_q[wa_idx_i] <= wdata_i;
    end
  end

  // reads see pre-write contents
  assign ra_data_o = mem_q[ra_idx_i];
  assign rb_data_o = mem_q[rb_idx_i];

endmodule

// File: rtl/bp_policy.sv
module bp_policy #(
  parameter int unsigned PC_W = 32
) (
  input  logic [2:0]      mode_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] target_i,
  input  logic            last_i,
  input  logic [1:0]      ctr_i,
  output logic            taken_o
);
  import bp_pkg::*;

  always_comb begin
    unique case (mode_i)
      POL_TAKEN:   taken_o = 1'b1;
      POL_NOTTKN:  taken_o = 1'b0;
      POL_DISP:    taken_o = (target_i < pc_i);
      POL_LAST:    taken_o = last_i;
      POL_BIMODAL: taken_o = ctr_i[1];
      default:     taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bp_miss_ctr.sv
module bp_miss_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/bp_dir_predict.sv
module bp_dir_predict #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned ALIGN = 2,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic [PC_W-1:0]  lkp_pc_i,
  input  logic [PC_W-1:0]  lkp_target_i,
  output logic             lkp_taken_o,
  input  logic             upd_valid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic [PC_W-1:0]  upd_target_i,
  input  logic             upd_taken_i,
  output logic [CNT_W-1:0] miss_cnt_o
);
  import bp_pkg::*;

  localparam int unsigned IDX_LO = ALIGN;

  logic [IDX_W-1:0] lkp_idx, upd_idx;
  logic             lkp_last, upd_last;
  logic [1:0]       lkp_ctr, upd_ctr, upd_ctr_nxt;
  logic             upd_pred;

  assign lkp_idx = lkp_pc_i[IDX_LO +: IDX_W];
  assign upd_idx = upd_pc_i[IDX_LO +: IDX_W];

  // one-bit last-outcome history
  bp_hist_table #(.IDX_W(IDX_W), .W(1), .INIT(1'b0)) u_last_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_idx_i (lkp_idx),
    .ra_data_o(lkp_last),
    .rb_idx_i (upd_idx),
    .rb_data_o(upd_last),
    .we_i     (upd_valid_i),
    .wa_idx_i (upd_idx),
    .wdata_i  (upd_taken_i)
  );

  // two-bit saturating counters
  bp_hist_table #(.IDX_W(IDX_W), .W(2), .INIT(CTR_RESET)) u_ctr_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_idx_i (lkp_idx),
    .ra_data_o(lkp_ctr),
    .rb_idx_i (upd_idx),
    .rb_data_o(upd_ctr),
    .we_i     (upd_valid_i),
    .wa_idx_i (upd_idx),
    .wdata_i  (upd_ctr_nxt)
  );

  assign upd_ctr_nxt = ctr_step(upd_ctr, upd_taken_i);

  bp_policy #(.PC_W(PC_W)) u_lkp_pol (
    .mode_i  (mode_i),
    .pc_i    (lkp_pc_i),
    .target_i(lkp_target_i),
    .last_i  (lkp_last),
    .ctr_i   (lkp_ctr),
    .taken_o (lkp_taken_o)
  );

  // re-derive what was predicted for the resolving branch
  bp_policy #(.PC_W(PC_W)) u_upd_pol (
    .mode_i  (mode_i),
    .pc_i    (upd_pc_i),
    .target_i(upd_target_i),
    .last_i  (upd_last),
    .ctr_i   (upd_ctr),
    .taken_o (upd_pred)
  );

  bp_miss_ctr #(.CNT_W(CNT_W)) u_miss (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (upd_valid_i && (upd_pred != upd_taken_i)),
    .cnt_o (miss_cnt_o)
  );

endmodule

// File: rtl/bp_dir_predict_chk.sv
module bp_dir_predict_chk #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned ALIGN = 2,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       mode_i,
  input logic [PC_W-1:0]  lkp_pc_i,
  input logic [PC_W-1:0]  lkp_target_i,
  input logic             lkp_taken_o,
  input logic             upd_valid_i,
  input logic [PC_W-1:0]  upd_pc_i,
  input logic             upd_taken_i,
  input logic [CNT_W-1:0] miss_cnt_o
);
  logic [IDX_W-1:0] l_idx, u_idx;
  assign l_idx = lkp_pc_i[ALIGN +: IDX_W];
  assign u_idx = upd_pc_i[ALIGN +: IDX_W];

  AST_FIXED_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0) |-> lkp_taken_o); // R1
  AST_FIXED_NOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd1) |-> !lkp_taken_o); // R2
  AST_DISP_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd2 && lkp_target_i < lkp_pc_i) |-> lkp_taken_o); // R3
  AST_DISP_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd2 && lkp_target_i >= lkp_pc_i) |-> !lkp_taken_o); // R3
  AST_LAST_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd3 && $past(upd_valid_i) && l_idx == $past(u_idx))
      |-> lkp_taken_o == $past(upd_taken_i)); // R4
  AST_CTR_TWO_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd4 && $past(upd_valid_i, 1) && $past(upd_valid_i, 2)
     && $past(upd_taken_i, 1) && $past(upd_taken_i, 2)
     && $past(u_idx, 1) == $past(u_idx, 2) && l_idx == $past(u_idx, 1))
      |-> lkp_taken_o); // R5
  AST_MISS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(miss_cnt_o)); // R9
  AST_MISS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> (miss_cnt_o == $past(miss_cnt_o)
                     || miss_cnt_o == $past(miss_cnt_o) + 1'b1)); // R9

endmodule

bind bp_dir_predict bp_dir_predict_chk #(
  .PC_W(PC_W), .ALIGN(ALIGN), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .lkp_pc_i    (lkp_pc_i),
  .lkp_target_i(lkp_target_i),
  .lkp_taken_o (lkp_taken_o),
  .upd_valid_i (upd_valid_i),
  .upd_pc_i    (upd_pc_i),
  .upd_taken_i (upd_taken_i),
  .miss_cnt_o  (miss_cnt_o)
);

// File: tb/bp_dir_predict_test.sv
`timescale 1ns/1ps
module bp_dir_predict_test;
  localparam int PC_W  = 32;
  localparam int ALIGN = 2;
  localparam int IDX_W = 6;
  localparam int CNT_W = 16;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [2:0]       mode = '0;
  logic [PC_W-1:0]  lpc = '0, ltgt = '0, upc = '0, utgt = '0;
  logic             uv = 1'b0, ut = 1'b0;
  logic             pred;
  logic [CNT_W-1:0] mcnt;

  int checks = 0;
  int errors = 0;
  int last_m [DEPTH];
  int ctr_m  [DEPTH];
  int cnt_m  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  bp_dir_predict #(.PC_W(PC_W), .ALIGN(ALIGN), .IDX_W(IDX_W), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .lkp_pc_i(lpc), .lkp_target_i(ltgt), .lkp_taken_o(pred),
    .upd_valid_i(uv), .upd_pc_i(upd_pc_w), .upd_target_i(utgt), .upd_taken_i(ut),
    .miss_cnt_o(mcnt)
  );
  wire [PC_W-1:0] upd_pc_w = upc;

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'((pc >> ALIGN) % DEPTH);
  endfunction

  function automatic int model_pred(int m, logic [PC_W-1:0] pc, logic [PC_W-1:0] tg);
    case (m)
      0: return 1;
      1: return 0;
      2: return (tg < pc) ? 1 : 0;
      3: return last_m[idx_of(pc)];
      4: return (ctr_m[idx_of(pc)] >= 2) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int m, logic [PC_W-1:0] lp, logic [PC_W-1:0] lt,
                      bit v, logic [PC_W-1:0] up, logic [PC_W-1:0] utg, bit t,
                      string tag);
    @(negedge clk);
    mode = 3'(m); lpc = lp; ltgt = lt; uv = v; upc = up; utgt = utg; ut = t;
    #1;
    check(tag, int'(pred), model_pred(m, lp, lt));
    check("R9 miss count", int'(mcnt), cnt_m);
    if (v) begin
      if (model_pred(m, up, utg) != int'(t)) cnt_m = (cnt_m + 1) % (1 << CNT_W);
      last_m[idx_of(up)] = t;
      if (t && ctr_m[idx_of(up)] < 3) ctr_m[idx_of(up)]++;
      if (!t && ctr_m[idx_of(up)] > 0) ctr_m[idx_of(up)]--;
    end
  endtask

  task automatic idle(int m, logic [PC_W-1:0] lp, string tag);
    step(m, lp, lp + 32'h40, 0, '0, '0, 0, tag);
  endtask

  task automatic loop_visit(int m, logic [PC_W-1:0] pc);
    for (int k = 0; k < 10; k++)
      step(m, pc, pc - 32'h20, 1, pc, pc - 32'h20, (k < 9), "R10 loop");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0;
    for (int i = 0; i < DEPTH; i++) begin last_m[i] = 0; ctr_m[i] = 1; end
    repeat (3) @(negedge clk);
    check("R6 miss count in reset", int'(mcnt), 0);
    rst_ni = 1'b1;

    // R6 reset contents
    idle(4, 32'h100, "R6 counter reset weak-not-taken");
    idle(3, 32'h104, "R6 last-bit reset zero");

    // R1 fixed taken, with not-taken training
    for (int i = 0; i < 6; i++)
      step(0, 32'h40 + 4*i, 32'h1000, 1, 32'h40 + 4*i, 32'h10, 0, "R1 fixed taken");
    // R2 fixed not taken, with taken training
    for (int i = 0; i < 6; i++)
      step(1, 32'h60 + 4*i, 32'h0, 1, 32'h60 + 4*i, 32'h0, 1, "R2 fixed not taken");

    // R3 displacement
    step(2, 32'h200, 32'h100, 0, '0, '0, 0, "R3 backward taken");
    step(2, 32'h200, 32'h300, 0, '0, '0, 0, "R3 forward not taken");
    step(2, 32'h200, 32'h200, 0, '0, '0, 0, "R3 equal not taken");
    step(2, 32'h204, 32'h0,   1, 32'h208, 32'h300, 1, "R3 backward with miss update");
    step(2, 32'h204, 32'h208, 1, 32'h208, 32'h100, 0, "R3 forward with miss update");

    // R11 train under policy 0, use under 3 and 4
    step(0, 32'h80, 32'h0, 1, 32'h80, 32'h0, 1, "R11 train");
    step(0, 32'h80, 32'h0, 1, 32'h80, 32'h0, 1, "R11 train");
    idle(3, 32'h80, "R11 last-bit trained under other policy");
    idle(4, 32'h80, "R11 counter trained under other policy");

    // R4 last outcome, R7 aliasing
    step(3, 32'h90, 32'h0, 1, 32'h90, 32'h0, 1, "R4 before taken write");
    idle(3, 32'h90, "R4 after taken write");
    idle(3, 32'h90 + (1 << (ALIGN + IDX_W)), "R7 alias shares entry");
    step(3, 32'h94, 32'h0, 1, 32'h90 + 32'h3000_0000, 32'h0, 0, "R7 alias write");
    idle(3, 32'h90, "R4 R7 after aliased not-taken write");

    // R5 saturation walk
    for (int i = 0; i < 3; i++) step(4, 32'hA0, 32'h0, 1, 32'hA0, 32'h0, 1, "R5 up");
    idle(4, 32'hA0, "R5 strongly taken");
    step(4, 32'hA0, 32'h0, 1, 32'hA0, 32'h0, 0, "R5 down from 11");
    idle(4, 32'hA0, "R5 weakly taken still taken");
    for (int i = 0; i < 4; i++) step(4, 32'hA0, 32'h0, 1, 32'hA0, 32'h0, 0, "R5 down");
    step(4, 32'hA0, 32'h0, 1, 32'hA0, 32'h0, 1, "R5 up from 00");
    idle(4, 32'hA0, "R5 weakly not taken");

    // R8 same-entry collision
    step(4, 32'hB0, 32'h0, 1, 32'hB0, 32'h0, 1, "R8 collision sees old 01");
    step(4, 32'hB0, 32'h0, 1, 32'hB0, 32'h0, 1, "R8 collision sees old 10");
    step(3, 32'hB4, 32'h0, 1, 32'hB4, 32'h0, 1, "R8 last-bit collision sees old 0");
    idle(3, 32'hB4, "R8 new value after edge");

    // R10 loop behaviour
    loop_visit(3, 32'hC0);
    idle(3, 32'hC0, "R10 settle");
    c0 = int'(mcnt);
    loop_visit(3, 32'hC0);
    idle(3, 32'hC0, "R10 settle");
    check("R10 one-bit misses per visit", int'(mcnt) - c0, 2);
    loop_visit(4, 32'hD0);
    loop_visit(4, 32'hD0);
    idle(4, 32'hD0, "R10 settle");
    c0 = int'(mcnt);
    loop_visit(4, 32'hD0);
    idle(4, 32'hD0, "R10 settle");
    check("R10 two-bit misses per visit", int'(mcnt) - c0, 1);

    // mixed stream, R9 against model every cycle
    for (int i = 0; i < 400; i++) begin
      int m;
      logic [PC_W-1:0] a, b;
      m = $urandom_range(0, 4);
      a = {$urandom_range(0, 7), 2'b00, 2'b00} + 32'h300;
      b = {$urandom_range(0, 7), 2'b00, 2'b00} + 32'h300;
      step(m, a, 32'($urandom_range(0, 32'h600)), ($urandom_range(0, 3) != 0),
           b, 32'($urandom_range(0, 32'h600)), $urandom_range(0, 1) == 1,
           "R9 mixed stream prediction");
    end
    idle(4, 32'h0, "R9 final");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule